// File: doc/BRIEF.md
# Serial Status Flag Clearing Logic

This block keeps the status word of a serial port. Single-cycle event strobes from the transmitter and receiver set sticky flags. The flags hold until the host clears them. The receiver busy bit is the one exception: it shows the receiver's live state and is never latched.

A flag is cleared in two steps. First the host reads the status word. That read arms every flag that is set at that moment. Next the host accesses the data register. A data read clears the armed receive flags, and a data write clears the armed transmit flags. Either access releases all arms, whether or not it cleared anything. A flag that sets after the status read is not armed, so it survives the data access.

A long-word read covers the status and data registers in one access. It clears the receive flags set at that instant without needing an earlier status read, and it never touches the two transmit flags.

Top module: `sci_flag_ctrl`

## Requirements
- R1: In reset, `stat_o` reads 16'h0180: transmit-empty (bit 8) and transmit-complete (bit 7) are 1, and every other bit is 0.
- R2: The status word has this layout: bit 8 transmit-empty, bit 7 transmit-complete, bit 6 receive-full, bit 5 receiver busy, bit 4 idle line, bit 3 overrun, bit 2 noise, bit 1 framing error, bit 0 parity error. Bits 15 to 9 always read 0.
- R3: An event strobe held high for one cycle sets its flag at the next clock edge. The flag stays set until it is cleared through a bus access.
- R4: A data read (`rd_i`=1, `sel_data_i`=1) clears the receive flags (bits 6, 4, 3, 2, 1, 0) that were set when the last status read (`rd_i`=1, `sel_data_i`=0, `long_i`=0) took place. A data read with no status read before it clears nothing.
- R5: A data write (`wr_i`=1, `sel_data_i`=1) clears bits 8 and 7 if they were armed by the last status read. A data write leaves the receive flags alone, and a data read leaves bits 8 and 7 alone.
- R6: A flag that sets after the status read and before the data access is not cleared by that access. It clears only after a later status read sees it set and a later data access follows.
- R7: Every data read, data write or long-word read releases all arms. A second data access with no new status read in between clears nothing.
- R8: A long-word read (`rd_i`=1, `sel_data_i`=0, `long_i`=1) clears every receive flag set in that cycle. It leaves bits 8 and 7 unchanged and needs no earlier status read.
- R9: When a flag's set event and its clear condition occur in the same cycle, the flag ends up set.
- R10: Overrun (bit 3) sets when a receive-full event arrives while bit 6 is set and bit 6 is not being cleared in that cycle.
- R11: Bit 5 follows `rx_busy_i` in the same cycle, and bus accesses have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_empty_ev_i | input | 1 | Strobe: transmit buffer became free |
| tx_done_ev_i | input | 1 | Strobe: transmitter went idle |
| rx_full_ev_i | input | 1 | Strobe: new receive character available |
| rx_busy_i | input | 1 | Receiver busy level |
| idle_ev_i | input | 1 | Strobe: idle line detected |
| noise_ev_i | input | 1 | Strobe: noise seen on received character |
| frame_ev_i | input | 1 | Strobe: framing error or break |
| parity_ev_i | input | 1 | Strobe: parity error |
| rd_i | input | 1 | Bus read strobe |
| wr_i | input | 1 | Bus write strobe (ignored when `rd_i` is high) |
| sel_data_i | input | 1 | 0 selects status, 1 selects data |
| long_i | input | 1 | Long-word qualifier for a status read |
| stat_o | output | 16 | Status word |

## Verification
A flag's set event and its clearing access can fall in the same cycle. The bench provokes this by pulsing an event strobe in the very cycle of the data read that would clear that flag. It then checks that the flag still reads 1 afterwards. A related case pulses receive-full during the clearing read of a set receive-full flag. There the bench expects receive-full to remain set and overrun not to appear.

// File: rtl/sci_flag_pkg.sv
package sci_flag_pkg;
  localparam int FLAG_W = 9;
  localparam int STAT_W = 16;

  localparam int B_TXE = 8;
  localparam int B_TXC = 7;
  localparam int B_RXF = 6;
  localparam int B_BSY = 5;
  localparam int B_IDL = 4;
  localparam int B_OVR = 3;
  localparam int B_NSE = 2;
  localparam int B_FRM = 1;
  localparam int B_PAR = 0;

  localparam logic [FLAG_W-1:0] RST_VAL = 9'h180;
  localparam logic [FLAG_W-1:0] TX_MASK = 9'h180;
  localparam logic [FLAG_W-1:0] RX_MASK = 9'h05F;

  typedef struct packed {
    logic arm_cap;
    logic arm_rel;
    logic clr_rx_armed;
    logic clr_tx_armed;
    logic clr_rx_all;
  } acc_ctl_t;
endpackage

// File: rtl/sci_acc_decode.sv
module sci_acc_decode
  import sci_flag_pkg::*;
(
  input  logic     rd_i,
  input  logic     wr_i,
  input  logic     sel_data_i,
  input  logic     long_i,
  output acc_ctl_t ctl_o
);
  logic rd_stat, rd_long, rd_data, wr_data;

  always_comb begin
    rd_stat = rd_i & ~sel_data_i & ~long_i;
    rd_long = rd_i & ~sel_data_i & long_i;
    rd_data = rd_i & sel_data_i;
    // read wins over a simultaneous write
    wr_data = wr_i & ~rd_i & sel_data_i;

    ctl_o.arm_cap      = rd_stat;
    ctl_o.arm_rel      = rd_data | wr_data | rd_long;
    ctl_o.clr_rx_armed = rd_data;
    ctl_o.clr_tx_armed = wr_data;
    ctl_o.clr_rx_all   = rd_long;
  end
endmodule

// File: rtl/sci_flag_cell.sv
module sci_flag_cell #(
  parameter logic RST = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic arm_cap_i,
  input  logic arm_rel_i,
  input  logic clr_armed_i,
  input  logic clr_all_i,
  output logic flag_o,
  output logic arm_o
);
  logic flag_q, arm_q, clr;

  assign clr = (clr_armed_i & arm_q) | clr_all_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= RST;
      arm_q  <= 1'b0;
    end else begin
      if (set_i)    flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
      if (arm_cap_i)      arm_q <= flag_q;
      else if (arm_rel_i) arm_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign arm_o  = arm_q;

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  assert_armed_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_armed_i && arm_q && !set_i) |=> !flag_q);
  assert_unarmed_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !arm_q && !clr_all_i && !set_i) |=> flag_q);
endmodule

// File: rtl/sci_flag_ctrl.sv
module sci_flag_ctrl
  import sci_flag_pkg::*;
#(
  parameter int STAT_WIDTH = STAT_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tx_empty_ev_i,
  input  logic                  tx_done_ev_i,
  input  logic                  rx_full_ev_i,
  input  logic                  rx_busy_i,
  input  logic                  idle_ev_i,
  input  logic                  noise_ev_i,
  input  logic                  frame_ev_i,
  input  logic                  parity_ev_i,
  input  logic                  rd_i,
  input  logic                  wr_i,
  input  logic                  sel_data_i,
  input  logic                  long_i,
  output logic [STAT_WIDTH-1:0] stat_o
);
  localparam int PAD_W = STAT_WIDTH - FLAG_W;

  acc_ctl_t          ctl;
  logic [FLAG_W-1:0] flags, arms, ev;
  logic              rxf_clr, ovr_ev;

  sci_acc_decode u_dec (
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .sel_data_i (sel_data_i),
    .long_i     (long_i),
    .ctl_o      (ctl)
  );

  // receive-full leaves this cycle: a later arrival is then not an overrun
  assign rxf_clr = (ctl.clr_rx_armed & arms[B_RXF]) | ctl.clr_rx_all;
  assign ovr_ev  = rx_full_ev_i & flags[B_RXF] & ~rxf_clr;

  always_comb begin
    ev        = '0;
    ev[B_TXE] = tx_empty_ev_i;
    ev[B_TXC] = tx_done_ev_i;
    ev[B_RXF] = rx_full_ev_i;
    ev[B_IDL] = idle_ev_i;
    ev[B_OVR] = ovr_ev;
    ev[B_NSE] = noise_ev_i;
    ev[B_FRM] = frame_ev_i;
    ev[B_PAR] = parity_ev_i;
  end

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    if (i == B_BSY) begin : g_live
      assign flags[i] = rx_busy_i;
      assign arms[i]  = 1'b0;
    end else begin : g_sticky
      sci_flag_cell #(.RST(RST_VAL[i])) u_cell (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .set_i       (ev[i]),
        .arm_cap_i   (ctl.arm_cap),
        .arm_rel_i   (ctl.arm_rel),
        .clr_armed_i (TX_MASK[i] ? ctl.clr_tx_armed : ctl.clr_rx_armed),
        .clr_all_i   (RX_MASK[i] ? ctl.clr_rx_all : 1'b0),
        .flag_o      (flags[i]),
        .arm_o       (arms[i])
      );
    end
  end

  assign stat_o = {{PAD_W{1'b0}}, flags};

  assert_long_keeps_tx_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl.clr_rx_all |=> ((flags[B_TXE:B_TXC] & $past(flags[B_TXE:B_TXC])) == $past(flags[B_TXE:B_TXC])));
  assert_overrun_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_ev_i && flags[B_RXF] && !rxf_clr) |=> flags[B_OVR]);
  assert_arm_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl.arm_rel |=> (arms == '0));
endmodule

// File: tb/sci_flag_ctrl_bench.sv
module sci_flag_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd = 0, wr = 0, sel = 0, lng = 0, busy = 0;
  logic [8:0] ev = '0;
  logic [15:0] stat;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  sci_flag_ctrl u_sci_flag_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_empty_ev_i(ev[8]), .tx_done_ev_i(ev[7]), .rx_full_ev_i(ev[6]),
    .rx_busy_i(busy), .idle_ev_i(ev[4]), .noise_ev_i(ev[2]),
    .frame_ev_i(ev[1]), .parity_ev_i(ev[0]),
    .rd_i(rd), .wr_i(wr), .sel_data_i(sel), .long_i(lng), .stat_o(stat)
  );

  task automatic chk(input logic [15:0] exp, input string req);
    n_cmp++;
    if (stat !== exp) begin
      n_bad++;
      $display("FAIL %s: stat=%h expected %h", req, stat, exp);
    end
  endtask

  task automatic cyc(input logic r, input logic w, input logic s, input logic l,
                     input logic [8:0] e);
    @(negedge clk);
    rd = r; wr = w; sel = s; lng = l; ev = e;
    @(negedge clk);
    rd = 0; wr = 0; sel = 0; lng = 0; ev = '0;
  endtask

  task automatic pulse(input logic [8:0] e); cyc(0, 0, 0, 0, e); endtask
  task automatic st_rd();  cyc(1, 0, 0, 0, '0); endtask
  task automatic dat_rd(); cyc(1, 0, 1, 0, '0); endtask
  task automatic dat_wr(); cyc(0, 1, 1, 0, '0); endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk(16'h0180, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(16'h0180, "R1 after release, R2 upper zero");
  endtask

  task automatic t_set();
    pulse(9'h057);
    chk(16'h01D7, "R3 set");
    repeat (3) @(negedge clk);
    chk(16'h01D7, "R3 sticky, R2 layout");
    dat_rd();
    chk(16'h01D7, "R4 data read without status read");
  endtask

  task automatic t_clear();
    st_rd(); dat_wr();
    chk(16'h0057, "R5 write clears tx only");
    st_rd(); dat_rd();
    chk(16'h0000, "R4 read clears rx");
    pulse(9'h180);
    st_rd(); dat_rd();
    chk(16'h0180, "R5 data read keeps tx");
    st_rd(); dat_wr();
    chk(16'h0000, "R5 armed write clears tx");
  endtask

  task automatic t_tx_race();
    pulse(9'h100);
    st_rd();
    pulse(9'h080);
    dat_wr();
    chk(16'h0080, "R6 tx race survives");
    dat_wr();
    chk(16'h0080, "R7 no re-arm on second write");
    st_rd(); dat_wr();
    chk(16'h0000, "R6 cleared after fresh read");
  endtask

  task automatic t_rx_race();
    pulse(9'h004);
    st_rd();
    pulse(9'h002);
    dat_rd();
    chk(16'h0002, "R6 rx race survives");
    dat_rd();
    chk(16'h0002, "R7 no re-arm on second read");
    st_rd(); dat_rd();
    chk(16'h0000, "R6 rx cleared after fresh read");
  endtask

  task automatic t_set_wins();
    pulse(9'h010);
    st_rd();
    cyc(1, 0, 1, 0, 9'h010);
    chk(16'h0010, "R9 set beats clear");
    st_rd(); dat_rd();
    chk(16'h0000, "R9 later clear");
  endtask

  task automatic t_overrun();
    pulse(9'h040);
    pulse(9'h040);
    chk(16'h0048, "R10 overrun sets");
    st_rd();
    cyc(1, 0, 1, 0, 9'h040);
    chk(16'h0040, "R10 no overrun on clearing read, R9");
    st_rd(); dat_rd();
    chk(16'h0000, "R10 cleanup");
  endtask

  task automatic t_long();
    pulse(9'h180);
    pulse(9'h041);
    chk(16'h01C1, "R3 mixed set");
    cyc(1, 0, 0, 1, '0);
    chk(16'h0180, "R8 long read keeps tx");
    dat_wr();
    chk(16'h0180, "R8 long read arms nothing");
  endtask

  task automatic t_busy();
    @(negedge clk); busy = 1'b1;
    #1 chk(16'h01A0, "R11 busy live");
    st_rd(); dat_rd();
    chk(16'h01A0, "R11 busy ignores access");
    @(negedge clk); busy = 1'b0;
    #1 chk(16'h0180, "R11 busy drops");
  endtask

  initial begin
    t_reset();
    t_set();
    t_clear();
    t_tx_race();
    t_rx_race();
    t_set_wins();
    t_overrun();
    t_long();
    t_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: stat=%h expected completion", stat);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule